// File: doc/BRIEF.md
# Wide-Word Element Permutation Unit

This block takes a 256-bit operand, views it as a packed array of equal-sized elements, and writes out a 256-bit result in which every destination element is a copy of some source element, or zero. Elements may be 8, 16 or 32 bits wide, giving 32, 16 or 8 elements per word. Element 0 always occupies the least significant bits.

The pattern comes from one of two places, picked per request. In vector mode, a second 256-bit operand, built by software beforehand, names the source element for every destination. In table mode, a small scalar index picks one of a set of built-in patterns: rotates, zero-filling shifts, interleaves, reversal, pair exchange, broadcast and a half-word exchange. The same pattern scales with the element size.

Requests enter through a valid/ready handshake and the result is held in an output register with its own valid/ready handshake. A request accepted on one clock edge is visible at the output right after that edge.

Top module: `perm_unit`

## Requirements
- R1: During and right after synchronous active-high reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A request accepted on an edge (`in_valid` and `in_ready` both 1) gives `out_valid` = 1 and its result on `out_data` after that same edge; `in_ready` equals `!out_valid || out_ready`; while `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` stay unchanged.
- R3: With `in_mode` = 0 (vector mode), destination element i takes source element k, where k is the low log2(N) bits of element i of `in_vec` (N = elements per word); all higher bits of `in_vec` are ignored.
- R4: `in_esz` selects the element size: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits; code 3 behaves as code 2.
- R5: With `in_mode` = 1 (table mode), `in_vec` has no effect on the result.
- R6: Table index 0 is identity; index 1 exchanges the two halves, so destination i takes source (i + N/2) mod N.
- R7: Index 2 rotates toward higher indices (destination i takes source (i-1) mod N); index 3 rotates toward lower indices (source (i+1) mod N).
- R8: Index 4 shifts toward higher indices with element 0 zeroed; index 5 shifts toward lower indices with element N-1 zeroed.
- R9: Index 6 interleaves the halves (destination 2j takes source j, destination 2j+1 takes source j+N/2); index 7 undoes it (destination j takes source 2j, destination j+N/2 takes source 2j+1, for j < N/2).
- R10: Index 8 reverses element order (source N-1-i); index 9 exchanges neighbours (source i XOR 1); index 10 broadcasts element 0 to every destination.
- R11: Table indices 11 to 255 give the identity result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_src | input | 256 | Operand whose elements are rearranged |
| in_vec | input | 256 | Permutation vector, used in vector mode |
| in_mode | input | 1 | 0 = vector mode, 1 = table mode |
| in_esz | input | 2 | Element size code |
| in_tidx | input | 8 | Table pattern index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 256 | Rearranged result |

## Verification
A wrong source index for any single destination byte shows on `out_data` one edge after the request is accepted, as a byte from the wrong position; because every byte of the test operands is distinct, each such error is visible at once. A wrong size decode misplaces whole groups of bytes on that same cycle. A broken handshake state shows either as a result that changes while held under backpressure or as `in_ready` disagreeing with `out_valid` and `out_ready` in the same cycle.

// File: rtl/perm_pkg.sv
package perm_pkg;

    localparam int DATA_W   = 256;
    localparam int NBYTES   = DATA_W / 8;
    localparam int BIDX_W   = $clog2(NBYTES);
    localparam int NSIZES   = 3;
    localparam int TBL_BITS = 4;

    typedef enum logic {
        MODE_VEC = 1'b0,
        MODE_TBL = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_32B = 2'd3
    } esz_e;

    typedef enum logic [TBL_BITS-1:0] {
        PAT_IDENT  = 4'd0,
        PAT_SWAP   = 4'd1,
        PAT_ROTUP  = 4'd2,
        PAT_ROTDN  = 4'd3,
        PAT_SHUP   = 4'd4,
        PAT_SHDN   = 4'd5,
        PAT_SHUF   = 4'd6,
        PAT_UNSHUF = 4'd7,
        PAT_REV    = 4'd8,
        PAT_PAIR   = 4'd9,
        PAT_BCAST  = 4'd10
    } pat_e;

    typedef struct packed {
        logic              zero;
        logic [BIDX_W-1:0] idx;
    } src_sel_t;

    // Source element for destination element i of a table pattern,
    // with 2**lg elements in the word.
    function automatic src_sel_t fixed_src(pat_e p, logic [BIDX_W-1:0] i,
                                           logic [2:0] lg);
        logic [BIDX_W:0] n;
        logic [BIDX_W:0] h;
        logic [BIDX_W:0] ii;
        logic [BIDX_W:0] r;
        logic [BIDX_W:0] nm;
        src_sel_t        s;
        n  = (BIDX_W+1)'(1) << lg;
        h  = n >> 1;
        nm = n - 1'b1;
        ii = {1'b0, i};
        s.zero = 1'b0;
        case (p)
            PAT_SWAP:   r = ii + h;
            PAT_ROTUP:  r = ii - 1'b1;
            PAT_ROTDN:  r = ii + 1'b1;
            PAT_SHUP: begin
                r = ii - 1'b1;
                s.zero = (ii == '0);
            end
            PAT_SHDN: begin
                r = ii + 1'b1;
                s.zero = (ii == nm);
            end
            PAT_SHUF:   r = (ii >> 1) + (ii[0] ? h : '0);
            PAT_UNSHUF: r = (ii < h) ? (ii << 1) : (((ii - h) << 1) + 1'b1);
            PAT_REV:    r = nm - ii;
            PAT_PAIR:   r = ii ^ (BIDX_W+1)'(1);
            PAT_BCAST:  r = '0;
            default:    r = ii;
        endcase
        s.idx = r[BIDX_W-1:0] & nm[BIDX_W-1:0];
        return s;
    endfunction

endpackage

// File: rtl/perm_index_gen.sv
module perm_index_gen
    import perm_pkg::*;
(
    input  mode_e                   mode,
    input  esz_e                    esz,
    input  pat_e                    pat,
    input  logic [DATA_W-1:0]       vec,
    output logic [NBYTES*BIDX_W-1:0] src_byte,
    output logic [NBYTES-1:0]       zero
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar k = 0; k < NSIZES; k++) begin : g_sz
            localparam int ELEM  = b >> k;
            localparam int LANE  = b & ((1 << k) - 1);
            localparam int FBYTE = b - LANE;
            localparam int LG    = BIDX_W - k;
            localparam logic [BIDX_W-1:0] MASK = BIDX_W'((1 << LG) - 1);

            src_sel_t           sel;
            logic [BIDX_W-1:0]  byte_idx;

            always_comb begin
                if (mode == MODE_VEC) begin
                    sel.zero = 1'b0;
                    sel.idx  = vec[FBYTE*8 +: BIDX_W] & MASK;
                end else begin
                    sel = fixed_src(pat, BIDX_W'(ELEM), 3'(LG));
                end
                byte_idx = (sel.idx << k) | BIDX_W'(LANE);
            end
        end

        always_comb begin
            unique case (esz)
                ESZ_8: begin
                    src_byte[b*BIDX_W +: BIDX_W] = g_sz[0].byte_idx;
                    zero[b]                      = g_sz[0].sel.zero;
                end
                ESZ_16: begin
                    src_byte[b*BIDX_W +: BIDX_W] = g_sz[1].byte_idx;
                    zero[b]                      = g_sz[1].sel.zero;
                end
                default: begin
                    src_byte[b*BIDX_W +: BIDX_W] = g_sz[2].byte_idx;
                    zero[b]                      = g_sz[2].sel.zero;
                end
            endcase
        end
    end

endmodule

// File: rtl/perm_byte_xbar.sv
module perm_byte_xbar
    import perm_pkg::*;
(
    input  logic [DATA_W-1:0]        src,
    input  logic [NBYTES*BIDX_W-1:0] src_byte,
    input  logic [NBYTES-1:0]        zero,
    output logic [DATA_W-1:0]        result
);

    logic [7:0] src_b [NBYTES];

    for (genvar b = 0; b < NBYTES; b++) begin : g_unpack
        assign src_b[b] = src[b*8 +: 8];
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_out
        logic [BIDX_W-1:0] sel;
        assign sel = src_byte[b*BIDX_W +: BIDX_W];
        assign result[b*8 +: 8] = zero[b] ? 8'h00 : src_b[sel];
    end

endmodule

// File: rtl/perm_unit.sv
module perm_unit
    import perm_pkg::*;
#(
    parameter int TIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_src,
    input  logic [DATA_W-1:0] in_vec,
    input  logic              in_mode,
    input  logic [1:0]        in_esz,
    input  logic [TIDX_W-1:0] in_tidx,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    pat_e                     pat;
    logic [NBYTES*BIDX_W-1:0] src_byte;
    logic [NBYTES-1:0]        zero;
    logic [DATA_W-1:0]        perm;
    logic                     accept;

    // Indices beyond the table fall back to identity.
    assign pat = (|(in_tidx >> TBL_BITS)) ? PAT_IDENT : pat_e'(in_tidx[TBL_BITS-1:0]);

    perm_index_gen u_idx (
        .mode     (mode_e'(in_mode)),
        .esz      (esz_e'(in_esz)),
        .pat      (pat),
        .vec      (in_vec),
        .src_byte (src_byte),
        .zero     (zero)
    );

    perm_byte_xbar u_xbar (
        .src      (in_src),
        .src_byte (src_byte),
        .zero     (zero),
        .result   (perm)
    );

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= perm;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/perm_unit_chk.sv
module perm_unit_chk
    import perm_pkg::*;
#(
    parameter int TIDX_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_src,
    input logic              in_mode,
    input logic [1:0]        in_esz,
    input logic [TIDX_W-1:0] in_tidx,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);

    a_r2_ready_rule: assert property (@(posedge clk) disable iff (rst)
        in_ready == (!out_valid || out_ready));

    a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    a_r2_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r6_identity: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_mode && in_tidx == '0)
        |=> out_data == $past(in_src));

    a_r6_half_exchange: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_mode && in_tidx == TIDX_W'(1) && in_esz == 2'd2)
        |=> out_data == {$past(in_src[DATA_W/2-1:0]), $past(in_src[DATA_W-1:DATA_W/2])});

endmodule

bind perm_unit perm_unit_chk #(.TIDX_W(TIDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_src    (in_src),
    .in_mode   (in_mode),
    .in_esz    (in_esz),
    .in_tidx   (in_tidx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/perm_unit_tb_top.sv
`timescale 1ns/1ps
module perm_unit_tb_top;

    localparam int W = 256;
    localparam int NV = 18;

    typedef struct packed {
        logic       mode;
        logic [1:0] esz;
        logic [7:0] tidx;
        logic [7:0] seed;
    } stim_t;

    localparam stim_t TBL [NV] = '{
        '{1'b0, 2'd0, 8'd0,   8'd1},
        '{1'b0, 2'd1, 8'd0,   8'd2},
        '{1'b0, 2'd2, 8'd0,   8'd3},
        '{1'b1, 2'd2, 8'd1,   8'd4},
        '{1'b1, 2'd0, 8'd1,   8'd5},
        '{1'b1, 2'd1, 8'd2,   8'd6},
        '{1'b1, 2'd2, 8'd3,   8'd7},
        '{1'b1, 2'd0, 8'd4,   8'd8},
        '{1'b1, 2'd2, 8'd5,   8'd9},
        '{1'b1, 2'd0, 8'd6,   8'd10},
        '{1'b1, 2'd1, 8'd7,   8'd11},
        '{1'b1, 2'd2, 8'd8,   8'd12},
        '{1'b1, 2'd1, 8'd9,   8'd13},
        '{1'b1, 2'd0, 8'd10,  8'd14},
        '{1'b1, 2'd2, 8'd0,   8'd15},
        '{1'b1, 2'd1, 8'd13,  8'd16},
        '{1'b1, 2'd0, 8'd16,  8'd17},
        '{1'b1, 2'd2, 8'd255, 8'd18}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_src = '0;
    logic [W-1:0] in_vec = '0;
    logic         in_mode = 1'b0;
    logic [1:0]   in_esz = 2'd0;
    logic [7:0]   in_tidx = 8'd0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [W-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    perm_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_src    (in_src),
        .in_vec    (in_vec),
        .in_mode   (in_mode),
        .in_esz    (in_esz),
        .in_tidx   (in_tidx),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // Distinct bytes in every operand so misplaced elements are visible.
    function automatic logic [W-1:0] mk_data(int seed);
        logic [W-1:0] d;
        for (int k = 0; k < 32; k++) d[k*8 +: 8] = 8'((k * 7 + seed * 29 + 1) % 256);
        return d;
    endfunction

    function automatic logic [W-1:0] ref_perm(logic [W-1:0] s, logic [W-1:0] v,
                                               logic m, logic [1:0] esz, logic [7:0] t);
        logic [W-1:0] r;
        int e, n, src;
        bit z;
        r = '0;
        e = (esz == 2'd0) ? 1 : (esz == 2'd1) ? 2 : 4;
        n = 32 / e;
        for (int i = 0; i < n; i++) begin
            z = 1'b0;
            src = i;
            if (!m) src = int'(v[i*e*8 +: 8]) % n;
            else begin
                case (int'(t))
                    1: src = (i + n/2) % n;
                    2: src = (i + n - 1) % n;
                    3: src = (i + 1) % n;
                    4: begin z = (i == 0); src = (i + n - 1) % n; end
                    5: begin z = (i == n - 1); src = (i + 1) % n; end
                    6: src = (i % 2 == 0) ? i / 2 : i / 2 + n / 2;
                    7: src = (i < n / 2) ? 2 * i : 2 * (i - n / 2) + 1;
                    8: src = n - 1 - i;
                    9: src = (i % 2 == 0) ? i + 1 : i - 1;
                    10: src = 0;
                    default: src = i;
                endcase
            end
            for (int k = 0; k < e; k++)
                r[(i*e + k)*8 +: 8] = z ? 8'h00 : s[(src*e + k)*8 +: 8];
        end
        return r;
    endfunction

    function automatic string tag_of(logic m, logic [7:0] t);
        if (!m) return "R3";
        case (int'(t))
            0, 1:      return "R6";
            2, 3:      return "R7";
            4, 5:      return "R8";
            6, 7:      return "R9";
            8, 9, 10:  return "R10";
            default:   return "R11";
        endcase
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_data(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one request at a negedge; it is taken at the next posedge.
    task automatic drive(logic [W-1:0] s, logic [W-1:0] v, logic m,
                         logic [1:0] esz, logic [7:0] t);
        @(negedge clk);
        in_valid = 1'b1;
        in_src   = s;
        in_vec   = v;
        in_mode  = m;
        in_esz   = esz;
        in_tidx  = t;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic run_one(string tag, logic [W-1:0] s, logic [W-1:0] v, logic m,
                           logic [1:0] esz, logic [7:0] t, logic [W-1:0] exp);
        drive(s, v, m, esz, t);
        @(negedge clk);
        check_bit({tag, " valid"}, out_valid, 1'b1);
        check_data(tag, out_data, exp);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] s, v, e1, e2, a;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R1 out_valid in reset", out_valid, 1'b0);
        check_bit("R1 in_ready in reset", in_ready, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 out_valid after reset", out_valid, 1'b0);
        check_bit("R1 in_ready after reset", in_ready, 1'b1);

        // Table of vectors
        for (int j = 0; j < NV; j++) begin
            s = mk_data(int'(TBL[j].seed));
            v = mk_data(int'(TBL[j].seed) + 100);
            run_one(tag_of(TBL[j].mode, TBL[j].tidx), s, v, TBL[j].mode,
                    TBL[j].esz, TBL[j].tidx,
                    ref_perm(s, v, TBL[j].mode, TBL[j].esz, TBL[j].tidx));
        end

        // R2: output drops once taken with no new request
        @(negedge clk);
        check_bit("R2 valid drops when idle", out_valid, 1'b0);

        // R3: upper bits of every vector field ignored
        s = mk_data(40);
        v = '0;
        for (int i = 0; i < 32; i++) v[i*8 +: 8] = 8'((31 - i) | 8'hE0);
        e1 = '0;
        for (int i = 0; i < 32; i++) e1[i*8 +: 8] = s[(31 - i)*8 +: 8];
        run_one("R3 upper vector bits", s, v, 1'b0, 2'd0, 8'd0, e1);

        // R4: size code 3 behaves as 32-bit
        s = mk_data(41);
        run_one("R4 size code 3", s, '0, 1'b1, 2'd3, 8'd8, ref_perm(s, '0, 1'b1, 2'd2, 8'd8));

        // R4: same pattern at each size differs
        s = mk_data(42);
        run_one("R4 16-bit reverse", s, '0, 1'b1, 2'd1, 8'd8, ref_perm(s, '0, 1'b1, 2'd1, 8'd8));

        // R5: table mode ignores the vector operand
        s = mk_data(43);
        e2 = ref_perm(s, '0, 1'b1, 2'd0, 8'd2);
        run_one("R5 vector zero", s, '0, 1'b1, 2'd0, 8'd2, e2);
        run_one("R5 vector ones", s, '1, 1'b1, 2'd0, 8'd2, e2);

        // R6: explicit half exchange at 32 bits
        s = mk_data(44);
        run_one("R6 half exchange", s, '0, 1'b1, 2'd2, 8'd1, {s[127:0], s[255:128]});

        // R2: backpressure holds the result
        s = mk_data(45);
        e1 = ref_perm(s, '0, 1'b1, 2'd0, 8'd9);
        @(negedge clk);
        out_ready = 1'b0;
        drive(s, '0, 1'b1, 2'd0, 8'd9);
        @(negedge clk);
        check_bit("R2 valid under stall", out_valid, 1'b1);
        check_bit("R2 ready low under stall", in_ready, 1'b0);
        a = mk_data(46);
        e2 = ref_perm(a, '0, 1'b1, 2'd1, 8'd6);
        in_valid = 1'b1;
        in_src   = a;
        in_vec   = '0;
        in_mode  = 1'b1;
        in_esz   = 2'd1;
        in_tidx  = 8'd6;
        @(negedge clk);
        check_data("R2 held under stall", out_data, e1);
        check_bit("R2 valid held", out_valid, 1'b1);
        out_ready = 1'b1;
        #0.1;
        check_bit("R2 ready follows out_ready", in_ready, 1'b1);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check_data("R2 next after release", out_data, e2);
        check_bit("R2 valid after release", out_valid, 1'b1);

        // R11: index just past the table and one with high bits set
        s = mk_data(47);
        run_one("R11 index 11", s, '0, 1'b1, 2'd0, 8'd11, s);
        run_one("R11 index 17", s, '0, 1'b1, 2'd1, 8'd17, s);

        // R1: reset clears a pending result
        @(negedge clk);
        out_ready = 1'b0;
        drive(mk_data(48), '0, 1'b1, 2'd0, 8'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_bit("R1 reset clears valid", out_valid, 1'b0);
        rst = 1'b0;
        out_ready = 1'b1;

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule